// File: doc/BRIEF.md
# RTC Timebase and Periodic Interrupt Generator

This block turns a 32768 Hz tick enable into the timing that a real-time clock needs. A one-second divider produces a one-clock update strobe that the calendar logic uses to advance its counters. The divider also flags an update-in-progress window over the last few ticks of every second, during which software should not read the time. The divider is controlled by a three-bit field. Two of its codes hold the chain in reset. Releasing the reset into a running code starts the first second from its midpoint.

A second counter generates the periodic interrupt. A four-bit rate code selects its period. Each expiry sets a sticky flag, which the enable gates onto the request line. Software may change the rate or the enable at any time. The next event is then placed one new period after the last event. If that point has already passed, the event fires on the next tick.

Top module: `rtc_timebase`

## Requirements
- R1: While running (divider code 0 to 2 and set mode off), `upd_o` is high for exactly one clock, in the cycle after the tick that completes each run of `TICKS_PER_SEC` ticks.
- R2: While running, `uip_o` is high from the tick that leaves `UIP_TICKS` ticks before the second boundary until the strobe. It is low in the cycle that `upd_o` is high.
- R3: With set mode on or a divider code above 2, no strobe is produced and `uip_o` is low. Raising set mode drops `uip_o` in the same cycle.
- R4: Divider codes 6 and 7 (bits 2:1 of `div_sel_i` both 1) hold the second divider at its midpoint. After a release into codes 0 to 2, the first strobe comes `TICKS_PER_SEC/2` ticks later. Codes 3 to 5 freeze the divider without resetting it.
- R5: `upd_ie_o` follows `uie_i` and is forced low in the same cycle while set mode is on.
- R6: Periodic rate code 0 gives no period. Code 1 gives 128 ticks, code 2 gives 256 ticks, and codes 3 to 15 give 2^(code-1) ticks.
- R7: With rate code 0 or `pie_i` low, no periodic event occurs. Ticks since the last event keep being counted.
- R8: After a change of rate code or `pie_i`, the next event falls one new period after the last event. If that many ticks have already elapsed, it falls on the next tick, and the extra time is dropped.
- R9: Each expiry sets `pf_o` one cycle after its tick. `pf_o` holds until `pf_clr_i`, and a simultaneous expiry wins over the clear. `pirq_o` is high exactly while `pf_o` and `pie_i` are both high.
- R10: After reset all outputs are low and both counters start from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Logic clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle enable at the 32768 Hz rate |
| div_sel_i | input | 3 | Divider control code |
| rate_sel_i | input | 4 | Periodic rate code |
| set_i | input | 1 | Set mode: stops updates and UIP |
| pie_i | input | 1 | Periodic interrupt enable |
| uie_i | input | 1 | Update interrupt enable as written |
| pf_clr_i | input | 1 | Clears the periodic flag |
| upd_o | output | 1 | One-clock update strobe |
| uip_o | output | 1 | Update-in-progress status |
| upd_ie_o | output | 1 | Effective update interrupt enable |
| pf_o | output | 1 | Sticky periodic flag |
| pirq_o | output | 1 | Periodic interrupt request |

## Verification
`upd_o` and a new `pf_o` are due one clock after the tick that causes them. `uip_o`, `upd_ie_o` and `pirq_o` respond to their control inputs in the same cycle. The bench drives a tick every cycle and keeps a cycle count from reset release, so expected strobe and flag cycles are plain arithmetic on that count. These cycles are queued when the stimulus is applied, and a monitor at the falling edge compares each observed strobe or flag rise with the head of its queue. Combinational responses are sampled one time step after the input change, inside the same cycle.

// File: rtl/rtc_tb_pkg.sv
package rtc_tb_pkg;
  localparam int unsigned RATE_W = 4;
  localparam int unsigned PER_W  = 15;

  function automatic logic [PER_W-1:0] rate_period(input logic [RATE_W-1:0] code);
    logic [PER_W-1:0] p;
    if (code == '0)                      p = '0;
    else if (code == RATE_W'(1))         p = PER_W'(128);
    else if (code == RATE_W'(2))         p = PER_W'(256);
    else                                 p = PER_W'(1) << (code - RATE_W'(1));
    return p;
  endfunction
endpackage

// File: rtl/rtc_sec_div.sv
module rtc_sec_div #(
  parameter int unsigned TICKS_PER_SEC = 32768,
  parameter int unsigned UIP_TICKS     = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic osc_en_i,
  input  logic div_hold_i,
  input  logic run_i,
  output logic upd_o,
  output logic uip_o
);
  localparam int unsigned CNT_W = $clog2(TICKS_PER_SEC);
  localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(TICKS_PER_SEC - 1);
  localparam logic [CNT_W-1:0] HALF_C  = CNT_W'(TICKS_PER_SEC / 2);
  localparam logic [CNT_W-1:0] UIP_C   = CNT_W'(TICKS_PER_SEC - UIP_TICKS);

  logic [CNT_W-1:0] cnt_q;
  logic             upd_q;
  logic             adv;

  assign adv = tick_i && osc_en_i && !div_hold_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      upd_q <= 1'b0;
    end else begin
      upd_q <= adv && run_i && (cnt_q == LAST_C);
      if (div_hold_i)      cnt_q <= HALF_C;  // release starts mid-second
      else if (adv)        cnt_q <= (cnt_q == LAST_C) ? '0 : cnt_q + 1'b1;
    end
  end

  assign upd_o = upd_q;
  assign uip_o = run_i && !div_hold_i && (cnt_q >= UIP_C);
endmodule

// File: rtl/rtc_periodic.sv
module rtc_periodic
  import rtc_tb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              pie_i,
  input  logic              pf_clr_i,
  output logic              pf_o,
  output logic              pirq_o
);
  logic [PER_W-1:0] period;
  logic [PER_W-1:0] ph_q;
  logic [PER_W-1:0] ph_inc;
  logic [PER_W:0]   ph_next_w;
  logic             active;
  logic             hit;
  logic             pf_q;

  assign period    = rate_period(rate_i);
  assign active    = pie_i && (period != '0);
  assign ph_next_w = {1'b0, ph_q} + 1'b1;
  assign ph_inc    = (ph_q == '1) ? ph_q : ph_next_w[PER_W-1:0];  // saturate
  // elapsed time beyond one period is dropped: fire at once
  assign hit       = tick_i && active && (ph_next_w >= {1'b0, period});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= '0;
      pf_q <= 1'b0;
    end else begin
      if (tick_i) ph_q <= hit ? '0 : ph_inc;
      if (hit)           pf_q <= 1'b1;
      else if (pf_clr_i) pf_q <= 1'b0;
    end
  end

  assign pf_o   = pf_q;
  assign pirq_o = pf_q && pie_i;
endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase
  import rtc_tb_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 32768,
  parameter int unsigned UIP_TICKS     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [2:0]        div_sel_i,
  input  logic [RATE_W-1:0] rate_sel_i,
  input  logic              set_i,
  input  logic              pie_i,
  input  logic              uie_i,
  input  logic              pf_clr_i,
  output logic              upd_o,
  output logic              uip_o,
  output logic              upd_ie_o,
  output logic              pf_o,
  output logic              pirq_o
);
  localparam logic [2:0] MAX_RUN_C = 3'd2;

  logic osc_en;
  logic div_hold;
  logic run;

  assign div_hold = &div_sel_i[2:1];
  assign osc_en   = (div_sel_i <= MAX_RUN_C);
  assign run      = osc_en && !set_i;
  assign upd_ie_o = uie_i && !set_i;

  rtc_sec_div #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .UIP_TICKS    (UIP_TICKS)
  ) u_sec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .osc_en_i  (osc_en),
    .div_hold_i(div_hold),
    .run_i     (run),
    .upd_o     (upd_o),
    .uip_o     (uip_o)
  );

  rtc_periodic u_per (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .rate_i  (rate_sel_i),
    .pie_i   (pie_i),
    .pf_clr_i(pf_clr_i),
    .pf_o    (pf_o),
    .pirq_o  (pirq_o)
  );
endmodule

// File: rtl/rtc_timebase_chk.sv
module rtc_timebase_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic [2:0] div_sel_i,
  input logic [3:0] rate_sel_i,
  input logic       set_i,
  input logic       pie_i,
  input logic       pf_clr_i,
  input logic       upd_o,
  input logic       uip_o,
  input logic       pf_o
);
  a_r1_upd_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |=> !upd_o);
  a_r1_upd_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> $past(tick_i));
  a_r2_uip_before_upd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> $past(uip_o));
  a_r3_quiet_when_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i || div_sel_i > 3'd2) |-> !uip_o);
  a_r7_no_pf_pie_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pie_i && !pf_o) |=> !pf_o);
  a_r7_no_pf_rate_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_sel_i == 4'd0 && !pf_o) |=> !pf_o);
  a_r9_pf_rise_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pf_o) |-> $past(tick_i));
  a_r9_pf_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pf_clr_i && !tick_i) |=> !pf_o);
endmodule

bind rtc_timebase rtc_timebase_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .div_sel_i (div_sel_i),
  .rate_sel_i(rate_sel_i),
  .set_i     (set_i),
  .pie_i     (pie_i),
  .pf_clr_i  (pf_clr_i),
  .upd_o     (upd_o),
  .uip_o     (uip_o),
  .pf_o      (pf_o)
);

// File: tb/sim_rtc_timebase.sv
module sim_rtc_timebase;
  localparam int TPS = 64;

  typedef struct { int cyc; string tag; } exp_t;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic [2:0] div_sel_i = 3'd2;
  logic [3:0] rate_sel_i = 4'd0;
  logic       set_i = 1'b0, pie_i = 1'b0, uie_i = 1'b1, pf_clr_i = 1'b0;
  logic       upd_o, uip_o, upd_ie_o, pf_o, pirq_o;

  int   n_chk = 0, n_fail = 0, cyc = 0;
  bit   auto_clr = 1'b1, done = 1'b0;
  logic pf_prev = 1'b0;
  exp_t upd_q[$], pf_q[$];

  rtc_timebase #(.TICKS_PER_SEC(TPS), .UIP_TICKS(8)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .div_sel_i(div_sel_i),
    .rate_sel_i(rate_sel_i), .set_i(set_i), .pie_i(pie_i), .uie_i(uie_i),
    .pf_clr_i(pf_clr_i), .upd_o(upd_o), .uip_o(uip_o), .upd_ie_o(upd_ie_o),
    .pf_o(pf_o), .pirq_o(pirq_o)
  );

  always #2 clk_i = ~clk_i;
  always @(posedge clk_i) if (rst_ni) cyc <= cyc + 1;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk_i);
  endtask

  // monitor: pops expected event cycles as the design produces them
  always @(negedge clk_i) begin : mon
    exp_t e;
    if (rst_ni && !done) begin
      if (upd_o) begin
        if (upd_q.size() == 0) chk("R3 unexpected update strobe", cyc, -1);
        else begin e = upd_q.pop_front(); chk(e.tag, cyc, e.cyc); end
      end
      if (pf_o && !pf_prev) begin
        if (pf_q.size() == 0) chk("R7 unexpected periodic flag", cyc, -1);
        else begin e = pf_q.pop_front(); chk(e.tag, cyc, e.cyc); end
      end
      pf_prev = pf_o;
      if (auto_clr) pf_clr_i = pf_o;
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : drv
    repeat (3) @(negedge clk_i);
    chk("R10 upd_o in reset", upd_o, 0);
    chk("R10 uip_o in reset", uip_o, 0);
    chk("R10 pf_o in reset", pf_o, 0);
    chk("R10 pirq_o in reset", pirq_o, 0);
    tick_i = 1'b1;
    upd_q.push_back('{TPS, "R1 first strobe"});
    upd_q.push_back('{2*TPS, "R1 second strobe"});
    rst_ni = 1'b1;

    wait_cyc(55);  chk("R2 uip low before window", uip_o, 0);
    wait_cyc(56);  chk("R2 uip high at window start", uip_o, 1);
    wait_cyc(63);  chk("R2 uip high on last tick", uip_o, 1);
    wait_cyc(64);  chk("R2 uip low with strobe", uip_o, 0);

    // set mode masks strobe at 192 and drops UIP at once
    wait_cyc(190); chk("R2 uip high before set", uip_o, 1);
    set_i = 1'b1; #1;
    chk("R3 set drops uip same cycle", uip_o, 0);
    chk("R5 set masks update enable", upd_ie_o, 0);
    wait_cyc(200);
    set_i = 1'b0; #1;
    chk("R5 update enable restored", upd_ie_o, 1);
    upd_q.push_back('{256, "R1 strobe after set mode"});

    // divider reset then release: strobe half a second later
    wait_cyc(260); div_sel_i = 3'b110;
    wait_cyc(280); chk("R4 uip low in divider reset", uip_o, 0);
    wait_cyc(300); div_sel_i = 3'd2;
    upd_q.push_back('{300 + TPS/2, "R4 half second after release"});
    upd_q.push_back('{300 + TPS/2 + TPS, "R4 full second after first"});
    wait_cyc(323); chk("R4 uip low before window", uip_o, 0);
    wait_cyc(324); chk("R4 uip high after release", uip_o, 1);

    // code 3 freezes the divider without reset
    wait_cyc(400); div_sel_i = 3'd3;
    wait_cyc(458); chk("R3 uip low while frozen", uip_o, 0);
    wait_cyc(464); div_sel_i = 3'd2;
    for (int k = 0; k < 9; k++) upd_q.push_back('{524 + k*TPS, "R3 strobe after freeze"});

    // periodic: stale elapsed time fires on next tick
    wait_cyc(530); rate_sel_i = 4'd3; pie_i = 1'b1;
    pf_q.push_back('{531, "R8 stale elapsed fires next tick"});
    pf_q.push_back('{535, "R6 code 3 period 4"});
    pf_q.push_back('{539, "R6 code 3 period 4"});
    pf_q.push_back('{543, "R6 code 3 period 4"});
    wait_cyc(545); rate_sel_i = 4'd5;
    pf_q.push_back('{559, "R8 longer period from last event"});
    wait_cyc(560); rate_sel_i = 4'd4;
    pf_q.push_back('{567, "R6 code 4 period 8"});
    wait_cyc(573); rate_sel_i = 4'd3;
    pf_q.push_back('{574, "R8 shorter period already elapsed"});
    pf_q.push_back('{578, "R6 code 3 period 4"});
    pf_q.push_back('{582, "R6 code 3 period 4"});
    wait_cyc(583); pie_i = 1'b0;
    wait_cyc(598);
    chk("R7 no flag with enable off", pf_o, 0);
    chk("R7 no request with enable off", pirq_o, 0);
    wait_cyc(600); pie_i = 1'b1;
    pf_q.push_back('{601, "R8 enable after long gap"});
    wait_cyc(603); rate_sel_i = 4'd0;
    wait_cyc(639); chk("R7 no flag with rate code 0", pf_o, 0);
    wait_cyc(640); rate_sel_i = 4'd1;
    pf_q.push_back('{729, "R6 code 1 period 128"});
    wait_cyc(730); rate_sel_i = 4'd2;
    pf_q.push_back('{985, "R6 code 2 period 256"});
    wait_cyc(986);
    auto_clr = 1'b0; pf_clr_i = 1'b0; rate_sel_i = 4'd3;
    pf_q.push_back('{989, "R9 flag one cycle after expiry"});
    wait_cyc(990);
    chk("R9 flag held", pf_o, 1);
    chk("R9 request with enable", pirq_o, 1);
    pie_i = 1'b0;
    wait_cyc(991);
    chk("R9 request drops with enable", pirq_o, 0);
    chk("R9 flag kept without enable", pf_o, 1);
    pf_clr_i = 1'b1;
    wait_cyc(992);
    pf_clr_i = 1'b0;
    chk("R9 flag cleared", pf_o, 0);

    wait_cyc(1045);
    done = 1'b1;
    chk("R1 pending strobes", upd_q.size(), 0);
    chk("R6 pending periodic events", pf_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule